// File: doc/BRIEF.md
# Split-Nibble CHR Bank and Mirroring Controller

This block sits in a cartridge bank mapper on the pattern-memory side. The CPU loads eight 8-bit bank numbers through a write port. Each bank number is built from two separate 4-bit writes: one write sets the low half and the write at the neighbouring address sets the high half. The PPU's 13-bit pattern space is split into eight 1 KiB windows. For the window that the current PPU address falls in, the block outputs the stored bank number with PPU bits 9:0 appended, which forms the extended CHR ROM address.

A 2-bit mirroring register selects how the PPU's nametable addresses map onto the two console nametable RAM halves. The block drives the CIRAM A10 select from that register. Two strap inputs pick the board variant. One shifts every bank number right by one bit, for boards that do not wire the low bank line. The other limits mirroring to vertical or horizontal, decided by the low bit of the stored value.

Top module: `chr_bank_mirror_ctl`

## Requirements
- R1: After reset all eight bank numbers are 0 and the mirroring register holds 0 (vertical), so `chr_addr[17:10]` reads 0 for every window and `ciram_a10` follows `ppu_addr[10]`.
- R2: A write whose address has bit 0 clear and that hits bank k loads `cpu_wdata[3:0]` into bits 3:0 of bank k. Bits 7:4 of that bank are left unchanged.
- R3: A write whose address has bit 0 set and that hits bank k loads `cpu_wdata[3:0]` into bits 7:4 of bank k. Bits 3:0 of that bank are left unchanged.
- R4: Bank k is addressed at $B000 + $1000*(k>>1) + 2*(k&1), with bit 0 choosing the half. Address bits 11:2 must be zero for the write to hit.
- R5: `chr_addr` equals {bank number of window `ppu_addr[12:10]`, `ppu_addr[9:0]`}.
- R6: When `drop_low_bit` is 1, the bank part of `chr_addr` is the stored bank number shifted right by one, with a 0 filled in at bit 7.
- R7: The mirroring register is loaded from `cpu_wdata[1:0]` only by a write to exactly $9000. Writes to $9001-$9003 leave it unchanged.
- R8: With `mirror_reduced` at 0, the mirroring modes map as follows: mode 0 gives `ciram_a10` = `ppu_addr[10]`; mode 1 gives `ppu_addr[11]`; mode 2 gives constant 0; mode 3 gives constant 1.
- R9: With `mirror_reduced` at 1, only bit 0 of the stored mode counts: 0 is vertical and 1 is horizontal. A write of $FF therefore gives horizontal, and a write of 2 gives vertical.
- R10: Writes outside the bank map, such as $A000, $B004, $B800 and $F000, leave every bank number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 4 | Low four bits of the CPU data bus |
| drop_low_bit | input | 1 | Variant strap: shift every bank number right by one |
| mirror_reduced | input | 1 | Variant strap: allow only vertical or horizontal mirroring |
| ppu_addr | input | 13 | PPU address, used for both pattern and nametable accesses |
| chr_addr | output | 18 | Extended CHR ROM address |
| ciram_a10 | output | 1 | Nametable RAM half select |

## Verification
A register write takes effect at the rising edge where `cpu_we` is sampled high. Both `chr_addr` and `ciram_a10` are combinational from the registers, the straps and `ppu_addr`, so each new result is due in that same cycle, straight after the edge. The bench drives each write at a falling edge and removes it at the next falling edge, which leaves exactly one rising edge in between. It then sets `ppu_addr` and samples one nanosecond later, well before the next rising edge. Checks of things that must stay unchanged read every window back through `chr_addr`, or probe `ciram_a10` with both A10 and A11 values.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORZ   = 2'd1,
      MIR_ONE_LO = 2'd2,
      MIR_ONE_HI = 2'd3
   } mirror_e;

   // Bank number after the optional wiring shift
   function automatic logic [7:0] shift_bank(input logic [7:0] raw, input logic drop);
      return drop ? {1'b0, raw[7:1]} : raw;
   endfunction

   // Effective mirroring mode for the selected variant
   function automatic mirror_e eff_mode(input logic [1:0] raw, input logic reduced);
      return reduced ? mirror_e'({1'b0, raw[0]}) : mirror_e'(raw);
   endfunction

endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode #(
   parameter int          ADDR_W      = 16,
   parameter int          NUM_WIN     = 8,
   parameter logic [3:0]  FIRST_PAGE  = 4'hB,
   parameter logic [15:0] MIRROR_ADDR = 16'h9000
) (
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   output logic [NUM_WIN-1:0] bank_we,
   output logic               hi_half,
   output logic               mir_we
);
   localparam int PAGES = NUM_WIN / 2;

   if ((NUM_WIN % 2) != 0) begin : g_bad_count
      $error("chr_wr_decode: NUM_WIN must be even");
   end
   if ((int'(FIRST_PAGE) + PAGES) > 16) begin : g_bad_page
      $error("chr_wr_decode: bank pages run past the top of the address space");
   end
   if (ADDR_W != 16) begin : g_bad_width
      $error("chr_wr_decode: ADDR_W must be 16");
   end

   logic [3:0] page;
   logic [3:0] rel;
   logic       mid_zero;
   logic       in_win;

   assign page     = cpu_addr[ADDR_W-1 -: 4];
   assign rel      = page - FIRST_PAGE;
   assign mid_zero = (cpu_addr[ADDR_W-5:2] == '0);
   assign in_win   = cpu_we && (page >= FIRST_PAGE) && (rel < 4'(PAGES)) && mid_zero;
   assign hi_half  = cpu_addr[0];
   assign mir_we   = cpu_we && (cpu_addr == MIRROR_ADDR);

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_sel
      assign bank_we[k] = in_win && (rel == 4'(k / 2)) && (cpu_addr[1] == 1'(k % 2));
   end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
   parameter int NUM_WIN = 8,
   parameter int NIB_W   = 4,
   localparam int BANK_W = 2 * NIB_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_WIN-1:0]        bank_we,
   input  logic                      hi_half,
   input  logic [NIB_W-1:0]          wdata,
   output logic [NUM_WIN*BANK_W-1:0] bank_flat
);
   for (genvar k = 0; k < NUM_WIN; k++) begin : g_bank
      logic [BANK_W-1:0] bank_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q <= '0;
         end else if (bank_we[k]) begin
            if (hi_half) bank_q[BANK_W-1:NIB_W] <= wdata;
            else         bank_q[NIB_W-1:0]      <= wdata;
         end
      end

      assign bank_flat[k*BANK_W +: BANK_W] = bank_q;
   end
endmodule

// File: rtl/chr_window_mux.sv
module chr_window_mux #(
   parameter int NUM_WIN = 8,
   parameter int BANK_W  = 8,
   parameter int OFS_W   = 10,
   localparam int IDX_W  = $clog2(NUM_WIN),
   localparam int PAT_W  = IDX_W + OFS_W,
   localparam int CHR_W  = BANK_W + OFS_W
) (
   input  logic [NUM_WIN*BANK_W-1:0] bank_flat,
   input  logic [PAT_W-1:0]          ppu_addr,
   input  logic                      drop_low_bit,
   output logic [CHR_W-1:0]          chr_addr
);
   if (BANK_W != 8) begin : g_bad_bank
      $error("chr_window_mux: the shift helper expects 8-bit bank numbers");
   end

   logic [IDX_W-1:0]  win_idx;
   logic [BANK_W-1:0] raw_bank;
   logic [BANK_W-1:0] eff_bank;

   assign win_idx  = ppu_addr[OFS_W +: IDX_W];
   assign raw_bank = bank_flat[win_idx*BANK_W +: BANK_W];
   assign eff_bank = chr_map_pkg::shift_bank(raw_bank, drop_low_bit);
   assign chr_addr = {eff_bank, ppu_addr[OFS_W-1:0]};
endmodule

// File: rtl/nt_mirror_sel.sv
module nt_mirror_sel
   import chr_map_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mir_we,
   input  logic [1:0] wdata,
   input  logic       mirror_reduced,
   input  logic       nt_a10,
   input  logic       nt_a11,
   output logic [1:0] mir_q,
   output logic       ciram_a10
);
   mirror_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mir_q <= 2'd0;
      else if (mir_we) mir_q <= wdata;
   end

   assign mode = eff_mode(mir_q, mirror_reduced);

   always_comb begin
      unique case (mode)
         MIR_VERT:   ciram_a10 = nt_a10;
         MIR_HORZ:   ciram_a10 = nt_a11;
         MIR_ONE_LO: ciram_a10 = 1'b0;
         MIR_ONE_HI: ciram_a10 = 1'b1;
         default:    ciram_a10 = nt_a10;
      endcase
   end
endmodule

// File: rtl/chr_bank_mirror_ctl.sv
module chr_bank_mirror_ctl #(
   parameter int          ADDR_W      = 16,
   parameter int          NUM_WIN     = 8,
   parameter int          NIB_W       = 4,
   parameter int          OFS_W       = 10,
   parameter logic [3:0]  FIRST_PAGE  = 4'hB,
   parameter logic [15:0] MIRROR_ADDR = 16'h9000,
   localparam int BANK_W = 2 * NIB_W,
   localparam int IDX_W  = $clog2(NUM_WIN),
   localparam int PAT_W  = IDX_W + OFS_W,
   localparam int CHR_W  = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [NIB_W-1:0]  cpu_wdata,
   input  logic              drop_low_bit,
   input  logic              mirror_reduced,
   input  logic [PAT_W-1:0]  ppu_addr,
   output logic [CHR_W-1:0]  chr_addr,
   output logic              ciram_a10
);
   if (OFS_W < 12 - 0 - 2 || PAT_W < 12) begin : g_bad_ofs
      $error("chr_bank_mirror_ctl: PPU address must reach bit 11 for mirroring");
   end

   logic [NUM_WIN-1:0]        bank_we;
   logic                      hi_half;
   logic                      mir_we;
   logic [NUM_WIN*BANK_W-1:0] bank_flat;
   logic [1:0]                mir_q;

   chr_wr_decode #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN),
      .FIRST_PAGE(FIRST_PAGE), .MIRROR_ADDR(MIRROR_ADDR)
   ) u_dec (
      .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .bank_we(bank_we), .hi_half(hi_half), .mir_we(mir_we)
   );

   chr_bank_regs #(.NUM_WIN(NUM_WIN), .NIB_W(NIB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .hi_half(hi_half),
      .wdata(cpu_wdata), .bank_flat(bank_flat)
   );

   chr_window_mux #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_mux (
      .bank_flat(bank_flat), .ppu_addr(ppu_addr),
      .drop_low_bit(drop_low_bit), .chr_addr(chr_addr)
   );

   nt_mirror_sel u_mir (
      .clk(clk), .rst_n(rst_n), .mir_we(mir_we), .wdata(cpu_wdata[1:0]),
      .mirror_reduced(mirror_reduced), .nt_a10(ppu_addr[10]), .nt_a11(ppu_addr[11]),
      .mir_q(mir_q), .ciram_a10(ciram_a10)
   );
endmodule

// File: rtl/chr_bank_mirror_ctl_chk.sv
module chr_bank_mirror_ctl_chk #(
   parameter int NUM_WIN = 8,
   parameter int BANK_W  = 8,
   parameter int PAT_W   = 13,
   parameter int CHR_W   = 18
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cpu_we,
   input logic [15:0]               cpu_addr,
   input logic [3:0]                cpu_wdata,
   input logic                      drop_low_bit,
   input logic                      mirror_reduced,
   input logic [PAT_W-1:0]          ppu_addr,
   input logic [CHR_W-1:0]          chr_addr,
   input logic                      ciram_a10,
   input logic [NUM_WIN*BANK_W-1:0] bank_flat,
   input logic [1:0]                mir_q
);
   for (genvar k = 0; k < NUM_WIN; k++) begin : g_k
      localparam logic [15:0] LO_ADDR = 16'hB000 + 16'(k / 2) * 16'h1000 + 16'(k % 2) * 16'd2;

      p_lo_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_we && cpu_addr == LO_ADDR) |=>
            (bank_flat[k*BANK_W +: 4] == $past(cpu_wdata)) &&
            $stable(bank_flat[k*BANK_W+4 +: 4]));

      p_hi_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_we && cpu_addr == (LO_ADDR | 16'd1)) |=>
            (bank_flat[k*BANK_W+4 +: 4] == $past(cpu_wdata)) &&
            $stable(bank_flat[k*BANK_W +: 4]));
   end

   p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chr_addr[9:0] == ppu_addr[9:0]);

   p_drop_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_low_bit |-> !chr_addr[CHR_W-1]);

   p_mirror_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr != 16'h9000) |=> $stable(mir_q));

   p_vertical_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mirror_reduced && mir_q == 2'd0) |-> ciram_a10 == ppu_addr[10]);

   p_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_reduced |-> ciram_a10 == (mir_q[0] ? ppu_addr[11] : ppu_addr[10]));

   p_outside_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && (cpu_addr[15:12] < 4'hB || cpu_addr[15:12] > 4'hE)) |=> $stable(bank_flat));
endmodule

bind chr_bank_mirror_ctl chr_bank_mirror_ctl_chk #(
   .NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .PAT_W(PAT_W), .CHR_W(CHR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .drop_low_bit(drop_low_bit),
   .mirror_reduced(mirror_reduced), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
   .ciram_a10(ciram_a10), .bank_flat(bank_flat), .mir_q(mir_q)
);

// File: tb/chr_bank_mirror_ctl_bench.sv
`timescale 1ns/1ps
module chr_bank_mirror_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [3:0]  cpu_wdata = '0;
   logic        drop_low_bit = 1'b0;
   logic        mirror_reduced = 1'b0;
   logic [12:0] ppu_addr = '0;
   logic [17:0] chr_addr;
   logic        ciram_a10;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_bank [8];
   logic [1:0] exp_mir;

   always #2 clk = ~clk;

   chr_bank_mirror_ctl u_chr_bank_mirror_ctl (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .drop_low_bit(drop_low_bit),
      .mirror_reduced(mirror_reduced), .ppu_addr(ppu_addr),
      .chr_addr(chr_addr), .ciram_a10(ciram_a10)
   );

   function automatic logic [15:0] bank_addr(input int k, input logic hi);
      return 16'hB000 + 16'(k / 2) * 16'h1000 + 16'(k % 2) * 16'd2 + {15'd0, hi};
   endfunction

   task automatic cpu_write(input logic [15:0] a, input logic [3:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_window(input string req, input int k, input logic [9:0] ofs);
      logic [7:0] b;
      ppu_addr = {3'(k), ofs};
      #1;
      b = drop_low_bit ? {1'b0, exp_bank[k][7:1]} : exp_bank[k];
      check(req, 32'(chr_addr), 32'({b, ofs}));
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < 8; k++) check_window(req, k, 10'(37 * k + 5));
   endtask

   task automatic check_mirror(input string req);
      logic [1:0] m;
      logic e;
      m = mirror_reduced ? {1'b0, exp_mir[0]} : exp_mir;
      for (int p = 0; p < 4; p++) begin
         ppu_addr = {1'b1, 2'(p), 10'h155};
         #1;
         case (m)
            2'd0: e = ppu_addr[10];
            2'd1: e = ppu_addr[11];
            2'd2: e = 1'b0;
            default: e = 1'b1;
         endcase
         check(req, 32'(ciram_a10), 32'(e));
      end
   endtask

   task automatic t_reset;
      check_all("R1 reset banks");
      check_mirror("R1 reset mirroring");
   endtask

   task automatic t_nibbles;
      cpu_write(16'hB000, 4'h5); exp_bank[0][3:0] = 4'h5;
      check_window("R2 low nibble", 0, 10'h3FF);
      cpu_write(16'hB001, 4'hA); exp_bank[0][7:4] = 4'hA;
      check_window("R3 high nibble", 0, 10'h000);
      cpu_write(16'hB000, 4'h3); exp_bank[0][3:0] = 4'h3;
      check_window("R2 low keeps high", 0, 10'h155);
      cpu_write(16'hB001, 4'h6); exp_bank[0][7:4] = 4'h6;
      check_window("R3 high keeps low", 0, 10'h2AA);
   endtask

   task automatic t_all_banks;
      for (int k = 0; k < 8; k++) begin
         cpu_write(bank_addr(k, 1'b0), 4'(k + 1));  exp_bank[k][3:0] = 4'(k + 1);
         cpu_write(bank_addr(k, 1'b1), 4'(15 - k)); exp_bank[k][7:4] = 4'(15 - k);
      end
      check_all("R4 R5 bank map and windows");
   endtask

   task automatic t_drop;
      drop_low_bit = 1'b1;
      check_all("R6 dropped low bit");
      drop_low_bit = 1'b0;
      check_all("R6 restored full bank");
   endtask

   task automatic t_ignored;
      cpu_write(16'hA000, 4'hF);
      cpu_write(16'hB004, 4'hF);
      cpu_write(16'hB800, 4'hF);
      cpu_write(16'hF000, 4'hF);
      cpu_write(16'hF002, 4'hF);
      check_all("R10 writes outside map");
   endtask

   task automatic t_mirror_full;
      for (int m = 0; m < 4; m++) begin
         cpu_write(16'h9000, 4'(m)); exp_mir = 2'(m);
         check_mirror("R8 mirroring mode");
      end
      cpu_write(16'h9000, 4'h1); exp_mir = 2'd1;
      cpu_write(16'h9002, 4'h3);
      cpu_write(16'h9001, 4'h2);
      cpu_write(16'h9003, 4'h0);
      check_mirror("R7 other addresses ignored");
   endtask

   task automatic t_mirror_reduced;
      mirror_reduced = 1'b1;
      cpu_write(16'h9000, 4'hF); exp_mir = 2'd3;
      check_mirror("R9 FF resolves horizontal");
      cpu_write(16'h9000, 4'h2); exp_mir = 2'd2;
      check_mirror("R9 two resolves vertical");
      mirror_reduced = 1'b0;
      check_mirror("R9 full decode again");
   endtask

   initial begin
      for (int k = 0; k < 8; k++) exp_bank[k] = '0;
      exp_mir = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_nibbles;
      t_all_banks;
      t_drop;
      t_ignored;
      t_mirror_full;
      t_mirror_reduced;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule